// File: doc/BRIEF.md
# Four-Slot In-Order Issue Gate with Register Scoreboard

This block sits at the decode/issue boundary of an in-order pipeline that can start up to four instructions per cycle. Decode hands it a group of up to four instructions over a valid/ready handshake. Each slot carries a valid bit, a destination register, two source registers and a resource class. The gate holds the group and works through it in program order. In every cycle it issues the longest run of still-waiting slots that are free of hazards, starting from the oldest one. It does not take a new group until every valid slot of the held group has issued.

Hazards come from two places. The first is older slots of the same group that are still waiting. Against these the gate checks read-after-write on the sources and write-after-write and write-after-read on the destination. The second is a one-bit-per-register pending-write table. A writer sets its bit when it issues, and either of two writeback ports clears it later. Structural hazards also stall a slot: a busy input per resource class, and a limit of one branch and one memory operation per cycle. Register 0 is hardwired and never takes part in a hazard. A flush input throws away the held group and leaves the pending-write table untouched.

Back-pressure follows the usual stream rules. A group transfers on a cycle where `grp_valid` and `grp_ready` are both high. The producer keeps the group stable while `grp_ready` is low. `grp_ready` depends only on the gate's held state and on `flush`, never on `grp_valid`.

Top module: `ig_issue_unit`

## Requirements
- R1: `grp_ready` is high exactly when no held slot is still waiting and `flush` is low. A group accepted at a clock edge can show up on `iss_mask` from the following cycle on, and `grp_ready` stays low until all of its valid slots have issued.
- R2: `iss_mask` is always a prefix of the waiting slots. A waiting slot that stalls keeps every younger slot of the group from issuing in that cycle.
- R3: A slot stalls when one of its sources equals the nonzero destination of an older waiting slot in the group.
- R4: A slot with a nonzero destination stalls when that destination equals the destination or a source of an older waiting slot in the group.
- R5: A slot stalls when a nonzero source or its nonzero destination has its pending-write bit set. An issued writer sets the bit at the issue edge, so the bit takes effect from the next cycle.
- R6: A writeback port clears its register's pending bit at the clock edge, and a slot held only by that bit issues in the next cycle. Both ports can clear in the same cycle. If a clear and a set of the same register fall in one cycle, the bit stays set.
- R7: Register 0 never gets a pending bit and never causes a hazard, as a source or as a destination.
- R8: Classes are encoded 0 = ALU, 1 = branch, 2 = memory, 3 = floating point. A slot whose class has its `res_busy` bit set stalls. A branch or memory slot stalls when an older waiting slot of the same class exists, so at most one of each issues per cycle.
- R9: While `flush` is high, nothing issues and `grp_ready` is low. The held group is dropped at that edge, `grp_ready` is high in the next cycle, and the pending bits are unchanged.
- R10: Slots whose valid bit is clear never issue, never block a younger slot, and never create a hazard. An accepted group with no valid slot leaves `grp_ready` high.
- R11: After reset, `grp_ready` is high, `iss_mask` is zero and no register is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | A group is offered |
| grp_ready | output | 1 | The gate can take a group |
| grp_slot_vld | input | SLOTS | Valid bit per slot, bit 0 is the oldest |
| grp_dst | input | SLOTS*RW | Destination register per slot, slot k at bits k*RW upward |
| grp_src_a | input | SLOTS*RW | First source register per slot |
| grp_src_b | input | SLOTS*RW | Second source register per slot |
| grp_cls | input | SLOTS*2 | Resource class per slot |
| res_busy | input | 4 | Busy flag per resource class |
| flush | input | 1 | Drop the held group |
| wb_vld | input | WB_PORTS | Writeback clear request per port |
| wb_reg | input | WB_PORTS*RW | Register cleared by each writeback port |
| iss_mask | output | SLOTS | Slots that issue in this cycle |

## Verification
`iss_mask` is combinational from the held group and the pending table, so a group accepted at edge t is judged during the cycle after t. A change to the pending table, whether a set at issue or a clear at writeback, affects the decision in the cycle after the edge that applies it. `flush` acts on `iss_mask` and `grp_ready` in the cycle where it is high. The driver queues one expected issue mask and ready value for every cycle it drives, applying inputs shortly after the rising edge. The monitor takes each expectation off the queue at the falling edge of that same cycle, so every comparison lands on the cycle the result is due.

// File: rtl/ig_pkg.sv
package ig_pkg;
  localparam int CLS_W   = 2;
  localparam int NUM_CLS = 1 << CLS_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU = 2'd0,
    CLS_BR  = 2'd1,
    CLS_MEM = 2'd2,
    CLS_FPU = 2'd3
  } ig_cls_e;
endpackage

// File: rtl/ig_group_hold.sv
module ig_group_hold
  import ig_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int RW    = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   flush,
  input  logic [SLOTS-1:0]       in_vld,
  input  logic [SLOTS*RW-1:0]    in_dst,
  input  logic [SLOTS*RW-1:0]    in_src_a,
  input  logic [SLOTS*RW-1:0]    in_src_b,
  input  logic [SLOTS*CLS_W-1:0] in_cls,
  input  logic [SLOTS-1:0]       iss,
  output logic [SLOTS-1:0]       left,
  output logic [SLOTS*RW-1:0]    h_dst,
  output logic [SLOTS*RW-1:0]    h_src_a,
  output logic [SLOTS*RW-1:0]    h_src_b,
  output logic [SLOTS*CLS_W-1:0] h_cls
);
  // Slots still waiting: cleared on flush, loaded on accept, trimmed on issue.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (flush) begin
      left <= '0;
    end else if (load) begin
      left <= in_vld;
    end else begin
      left <= left & ~iss;
    end
  end

  // Payload is only captured on accept; no reset needed.
  always_ff @(posedge clk) begin
    if (load) begin
      h_dst   <= in_dst;
      h_src_a <= in_src_a;
      h_src_b <= in_src_b;
      h_cls   <= in_cls;
    end
  end
endmodule

// File: rtl/ig_hazard_net.sv
module ig_hazard_net
  import ig_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int RW    = 5,
  parameter int NREG  = 32
) (
  input  logic [SLOTS-1:0]       left,
  input  logic [SLOTS*RW-1:0]    dst,
  input  logic [SLOTS*RW-1:0]    src_a,
  input  logic [SLOTS*RW-1:0]    src_b,
  input  logic [SLOTS*CLS_W-1:0] cls,
  input  logic [NREG-1:0]        sb_pend,
  input  logic [NUM_CLS-1:0]     res_busy,
  input  logic                   flush,
  output logic [SLOTS-1:0]       iss
);
  logic [SLOTS-1:0] ok;
  logic             stall_run;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [RW-1:0]    d_k, a_k, b_k;
    logic [CLS_W-1:0] c_k;
    logic             raw_h, wx_h, st_h;

    assign d_k = dst[k*RW +: RW];
    assign a_k = src_a[k*RW +: RW];
    assign b_k = src_b[k*RW +: RW];
    assign c_k = cls[k*CLS_W +: CLS_W];

    always_comb begin
      // Against in-flight writers recorded in the pending table.
      raw_h = ((a_k != '0) && sb_pend[a_k]) || ((b_k != '0) && sb_pend[b_k]);
      wx_h  = (d_k != '0) && sb_pend[d_k];
      st_h  = res_busy[c_k];
      // Against every older slot of the group that is still waiting.
      for (int j = 0; j < k; j++) begin
        if (left[j]) begin
          if ((dst[j*RW +: RW] != '0) &&
              ((a_k == dst[j*RW +: RW]) || (b_k == dst[j*RW +: RW])))
            raw_h = 1'b1;
          if ((d_k != '0) &&
              ((d_k == dst[j*RW +: RW]) || (d_k == src_a[j*RW +: RW]) ||
               (d_k == src_b[j*RW +: RW])))
            wx_h = 1'b1;
          if ((c_k == cls[j*CLS_W +: CLS_W]) &&
              ((c_k == CLS_BR) || (c_k == CLS_MEM)))
            st_h = 1'b1;
        end
      end
    end

    assign ok[k] = !(raw_h || wx_h || st_h);
  end

  // Program-order prefix: the first waiting slot that stalls closes the run.
  always_comb begin
    stall_run = 1'b0;
    iss       = '0;
    for (int k = 0; k < SLOTS; k++) begin
      iss[k] = left[k] && ok[k] && !stall_run && !flush;
      if (left[k] && !ok[k]) stall_run = 1'b1;
    end
  end
endmodule

// File: rtl/ig_pend_board.sv
module ig_pend_board #(
  parameter int NREG     = 32,
  parameter int RW       = 5,
  parameter int SLOTS    = 4,
  parameter int WB_PORTS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOTS-1:0]       iss,
  input  logic [SLOTS*RW-1:0]    dst,
  input  logic [WB_PORTS-1:0]    wb_vld,
  input  logic [WB_PORTS*RW-1:0] wb_reg,
  output logic [NREG-1:0]        sb_pend
);
  logic [NREG-1:0] set_v, clr_v, pend_d;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int k = 0; k < SLOTS; k++)
      if (iss[k]) set_v[dst[k*RW +: RW]] = 1'b1;
    for (int p = 0; p < WB_PORTS; p++)
      if (wb_vld[p]) clr_v[wb_reg[p*RW +: RW]] = 1'b1;
    // A set in the same cycle as a clear wins.
    pend_d    = (sb_pend & ~clr_v) | set_v;
    pend_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sb_pend <= '0;
    else        sb_pend <= pend_d;
  end
endmodule

// File: rtl/ig_issue_unit.sv
module ig_issue_unit
  import ig_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int NREG     = 32,
  parameter int WB_PORTS = 2,
  localparam int RW      = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   grp_valid,
  output logic                   grp_ready,
  input  logic [SLOTS-1:0]       grp_slot_vld,
  input  logic [SLOTS*RW-1:0]    grp_dst,
  input  logic [SLOTS*RW-1:0]    grp_src_a,
  input  logic [SLOTS*RW-1:0]    grp_src_b,
  input  logic [SLOTS*CLS_W-1:0] grp_cls,
  input  logic [NUM_CLS-1:0]     res_busy,
  input  logic                   flush,
  input  logic [WB_PORTS-1:0]    wb_vld,
  input  logic [WB_PORTS*RW-1:0] wb_reg,
  output logic [SLOTS-1:0]       iss_mask
);
  logic [SLOTS-1:0]       grp_left;
  logic [SLOTS*RW-1:0]    hold_dst, hold_src_a, hold_src_b;
  logic [SLOTS*CLS_W-1:0] hold_cls;
  logic [NREG-1:0]        sb_pend;
  logic                   grp_take;

  assign grp_ready = !(|grp_left) && !flush;
  assign grp_take  = grp_valid && grp_ready;

  ig_group_hold #(.SLOTS(SLOTS), .RW(RW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (grp_take),
    .flush    (flush),
    .in_vld   (grp_slot_vld),
    .in_dst   (grp_dst),
    .in_src_a (grp_src_a),
    .in_src_b (grp_src_b),
    .in_cls   (grp_cls),
    .iss      (iss_mask),
    .left     (grp_left),
    .h_dst    (hold_dst),
    .h_src_a  (hold_src_a),
    .h_src_b  (hold_src_b),
    .h_cls    (hold_cls)
  );

  ig_hazard_net #(.SLOTS(SLOTS), .RW(RW), .NREG(NREG)) u_haz (
    .left     (grp_left),
    .dst      (hold_dst),
    .src_a    (hold_src_a),
    .src_b    (hold_src_b),
    .cls      (hold_cls),
    .sb_pend  (sb_pend),
    .res_busy (res_busy),
    .flush    (flush),
    .iss      (iss_mask)
  );

  ig_pend_board #(.NREG(NREG), .RW(RW), .SLOTS(SLOTS), .WB_PORTS(WB_PORTS)) u_board (
    .clk     (clk),
    .rst_n   (rst_n),
    .iss     (iss_mask),
    .dst     (hold_dst),
    .wb_vld  (wb_vld),
    .wb_reg  (wb_reg),
    .sb_pend (sb_pend)
  );
endmodule

// File: rtl/ig_issue_unit_chk.sv
module ig_issue_unit_chk
  import ig_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int RW    = 5,
  parameter int NREG  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   grp_valid,
  input logic                   grp_ready,
  input logic [SLOTS-1:0]       grp_slot_vld,
  input logic [SLOTS-1:0]       iss_mask,
  input logic [SLOTS-1:0]       grp_left,
  input logic [NREG-1:0]        sb_pend,
  input logic [SLOTS*RW-1:0]    hold_dst,
  input logic [SLOTS*CLS_W-1:0] hold_cls
);
  logic             prefix_ok, seen_stall;
  logic [SLOTS-1:0] br_iss, mem_iss;

  always_comb begin
    prefix_ok  = 1'b1;
    seen_stall = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (grp_left[k] && !iss_mask[k]) seen_stall = 1'b1;
      else if (iss_mask[k] && seen_stall) prefix_ok = 1'b0;
      br_iss[k]  = iss_mask[k] && (hold_cls[k*CLS_W +: CLS_W] == CLS_BR);
      mem_iss[k] = iss_mask[k] && (hold_cls[k*CLS_W +: CLS_W] == CLS_MEM);
    end
  end

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready && (|grp_slot_vld)) |=> !grp_ready);

  // R2
  issue_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prefix_ok);

  // R10
  issue_waiting_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_mask & ~grp_left) == '0);

  // R8
  one_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(br_iss) <= 1);

  // R8
  one_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_iss) <= 1);

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_mask == '0 && !grp_ready));

  // R9
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (grp_left == '0));

  // R7
  zero_reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_pend[0]);

  for (genvar k = 0; k < SLOTS; k++) begin : g_set
    // R5
    set_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_mask[k] && (hold_dst[k*RW +: RW] != '0)) |=> sb_pend[$past(hold_dst[k*RW +: RW])]);
  end
endmodule

bind ig_issue_unit ig_issue_unit_chk #(.SLOTS(SLOTS), .RW(RW), .NREG(NREG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .grp_valid    (grp_valid),
  .grp_ready    (grp_ready),
  .grp_slot_vld (grp_slot_vld),
  .iss_mask     (iss_mask),
  .grp_left     (grp_left),
  .sb_pend      (sb_pend),
  .hold_dst     (hold_dst),
  .hold_cls     (hold_cls)
);

// File: tb/ig_issue_unit_tb_top.sv
module ig_issue_unit_tb_top;
  localparam int SLOTS = 4;
  localparam int NREG  = 32;
  localparam int RW    = 5;
  localparam int WBP   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               grp_valid = 1'b0;
  logic               grp_ready;
  logic [SLOTS-1:0]   grp_slot_vld = '0;
  logic [SLOTS*RW-1:0] grp_dst = '0, grp_src_a = '0, grp_src_b = '0;
  logic [SLOTS*2-1:0] grp_cls = '0;
  logic [3:0]         res_busy = '0;
  logic               flush = 1'b0;
  logic [WBP-1:0]     wb_vld = '0;
  logic [WBP*RW-1:0]  wb_reg = '0;
  logic [SLOTS-1:0]   iss_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [SLOTS-1:0] mask;
    logic             rdy;
    string            tag;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;

  ig_issue_unit #(.SLOTS(SLOTS), .NREG(NREG), .WB_PORTS(WBP)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .grp_valid    (grp_valid),
    .grp_ready    (grp_ready),
    .grp_slot_vld (grp_slot_vld),
    .grp_dst      (grp_dst),
    .grp_src_a    (grp_src_a),
    .grp_src_b    (grp_src_b),
    .grp_cls      (grp_cls),
    .res_busy     (res_busy),
    .flush        (flush),
    .wb_vld       (wb_vld),
    .wb_reg       (wb_reg),
    .iss_mask     (iss_mask)
  );

  // Monitor: one expectation per driven cycle, compared mid-cycle.
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      checks++;
      if (iss_mask !== e.mask || grp_ready !== e.rdy) begin
        failures++;
        $display("FAIL %s: iss_mask=%b ready=%b expected iss_mask=%b ready=%b",
                 e.tag, iss_mask, grp_ready, e.mask, e.rdy);
      end
    end
  end

  task automatic ins(input int k, input int d, input int a, input int b, input int c);
    grp_dst[k*RW +: RW]   = RW'(d);
    grp_src_a[k*RW +: RW] = RW'(a);
    grp_src_b[k*RW +: RW] = RW'(b);
    grp_cls[k*2 +: 2]     = 2'(c);
  endtask

  task automatic put(input logic [SLOTS-1:0] v);
    grp_slot_vld = v;
    grp_valid    = 1'b1;
  endtask

  task automatic wb(input int p, input int r);
    wb_vld[p]         = 1'b1;
    wb_reg[p*RW +: RW] = RW'(r);
  endtask

  // Driver: queue what this cycle must show, then advance one cycle.
  task automatic step(input logic [SLOTS-1:0] m, input logic r, input string tag);
    exp_t e;
    e.mask = m; e.rdy = r; e.tag = tag;
    expq.push_back(e);
    @(posedge clk); #2;
    grp_valid = 1'b0;
    flush     = 1'b0;
    wb_vld    = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    step(4'b0000, 1'b1, "R11 idle after reset");

    // Independent group
    ins(0, 1, 2, 3, 0); ins(1, 4, 5, 6, 0); ins(2, 7, 8, 9, 0); ins(3, 10, 11, 12, 0);
    put(4'b1111);
    step(4'b0000, 1'b1, "R1 accept cycle");
    step(4'b1111, 1'b0, "R1 independent group issues at once");
    wb(0, 1); wb(1, 4);
    step(4'b0000, 1'b0 | 1'b1, "R1 ready once group drained");
    wb(0, 7); wb(1, 10);
    step(4'b0000, 1'b1, "R6 cleanup");

    // Intra-group RAW then pending-source stall
    ins(0, 13, 14, 15, 0); ins(1, 16, 13, 14, 0); ins(2, 17, 18, 19, 0); ins(3, 20, 21, 22, 0);
    put(4'b1111);
    step(4'b0000, 1'b1, "R3 load");
    step(4'b0001, 1'b0, "R3 RAW in group stops slot1 and younger");
    wb(0, 13);
    step(4'b0000, 1'b0, "R5 pending source stalls");
    step(4'b1110, 1'b0, "R6 cleared source issues next cycle");
    wb(0, 16); wb(1, 17);
    step(4'b0000, 1'b1, "R1 ready after last slots");
    wb(0, 20);
    step(4'b0000, 1'b1, "R6 cleanup");

    // WAR, WAW and pending destination
    ins(0, 1, 2, 3, 0); ins(1, 2, 4, 5, 0); ins(2, 6, 7, 8, 0); ins(3, 6, 9, 10, 0);
    put(4'b1111);
    step(4'b0000, 1'b1, "R4 load");
    step(4'b0001, 1'b0, "R4 WAR on older source");
    step(4'b0110, 1'b0, "R4 WAW on older destination");
    wb(0, 6);
    step(4'b0000, 1'b0, "R5 pending destination stalls");
    step(4'b1000, 1'b0, "R6 destination cleared");
    wb(0, 1); wb(1, 2);
    step(4'b0000, 1'b1, "R6 two ports clear together");
    wb(0, 6);
    step(4'b0000, 1'b1, "R6 cleanup");

    // Register 0
    ins(0, 0, 1, 2, 0); ins(1, 3, 0, 0, 0); ins(2, 0, 4, 0, 0); ins(3, 5, 0, 6, 0);
    put(4'b1111);
    step(4'b0000, 1'b1, "R7 load");
    step(4'b1111, 1'b0, "R7 register 0 causes no hazard");
    ins(0, 8, 0, 0, 0);
    put(4'b0001); wb(0, 3); wb(1, 5);
    step(4'b0000, 1'b1, "R7 load reader of register 0");
    step(4'b0001, 1'b0, "R7 register 0 never pending");
    wb(0, 8);
    step(4'b0000, 1'b1, "R7 cleanup");

    // One branch and one memory op per cycle
    ins(0, 0, 1, 2, 1); ins(1, 0, 3, 4, 1); ins(2, 7, 8, 0, 2); ins(3, 9, 10, 0, 2);
    put(4'b1111);
    step(4'b0000, 1'b1, "R8 load");
    step(4'b0001, 1'b0, "R8 second branch waits");
    step(4'b0110, 1'b0, "R8 second memory op waits");
    step(4'b1000, 1'b0, "R8 last memory op");
    wb(0, 7); wb(1, 9);
    step(4'b0000, 1'b1, "R8 cleanup");

    // Busy resource
    ins(0, 11, 12, 13, 0); ins(1, 14, 15, 0, 2); ins(2, 0, 16, 0, 0); ins(3, 0, 17, 0, 0);
    put(4'b1111); res_busy = 4'b0100;
    step(4'b0000, 1'b1, "R8 load");
    step(4'b0001, 1'b0, "R8 busy memory class blocks");
    step(4'b0000, 1'b0, "R8 busy persists");
    res_busy = 4'b0000;
    step(4'b1110, 1'b0, "R8 busy released");
    wb(0, 11); wb(1, 14);
    step(4'b0000, 1'b1, "R8 cleanup");

    // Invalid slots
    ins(0, 15, 16, 17, 0); ins(1, 18, 15, 0, 0); ins(2, 19, 18, 20, 0); ins(3, 0, 0, 0, 0);
    put(4'b0101);
    step(4'b0000, 1'b1, "R10 load");
    step(4'b0101, 1'b0, "R10 invalid slots skipped");
    put(4'b0000); wb(0, 15); wb(1, 19);
    step(4'b0000, 1'b1, "R10 empty group load");
    step(4'b0000, 1'b1, "R10 empty group keeps ready");

    // Flush of an issuable group
    ins(0, 21, 22, 23, 0); ins(1, 24, 25, 0, 0);
    put(4'b0011);
    step(4'b0000, 1'b1, "R9 load");
    flush = 1'b1;
    step(4'b0000, 1'b0, "R9 flush blocks issue and ready");
    step(4'b0000, 1'b1, "R9 ready after flush");
    ins(0, 26, 21, 0, 0);
    put(4'b0001);
    step(4'b0000, 1'b1, "R9 load probe");
    step(4'b0001, 1'b0, "R9 flushed writer left no pending bit");
    wb(0, 26);
    step(4'b0000, 1'b1, "R9 cleanup");

    // Flush of a stalled group keeps pending bits
    ins(0, 21, 22, 23, 0); ins(1, 24, 21, 0, 0);
    put(4'b0011);
    step(4'b0000, 1'b1, "R9 load");
    step(4'b0001, 1'b0, "R3 reader waits on older writer");
    flush = 1'b1;
    step(4'b0000, 1'b0, "R9 flush stalled group");
    step(4'b0000, 1'b1, "R9 ready after flush");
    ins(0, 25, 21, 0, 0);
    put(4'b0001);
    step(4'b0000, 1'b1, "R9 load probe");
    wb(0, 21);
    step(4'b0000, 1'b0, "R9 pending bit kept across flush");
    step(4'b0001, 1'b0, "R6 issue after clear");
    wb(0, 25);
    step(4'b0000, 1'b1, "R9 cleanup");

    // Clear and set of the same register in one cycle
    ins(0, 27, 1, 2, 0);
    put(4'b0001);
    step(4'b0000, 1'b1, "R6 load writer");
    wb(0, 27);
    step(4'b0001, 1'b0, "R6 writer issues while its register is cleared");
    ins(0, 28, 27, 0, 0);
    put(4'b0001);
    step(4'b0000, 1'b1, "R6 load reader");
    wb(1, 27);
    step(4'b0000, 1'b0, "R6 set beat same-cycle clear");
    step(4'b0001, 1'b0, "R6 reader issues after port 1 clear");
    wb(0, 28);
    step(4'b0000, 1'b1, "R6 final idle");

    @(negedge clk); #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, all requirements unchecked");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule